// File: doc/BRIEF.md
# Dual-Channel Queued Audio Sample Streamer

This block sits on a parallel host bus and feeds a two-channel, parallel-input digital-to-analog converter. The host writes 8-bit unsigned samples. Bit 0 of the bus address picks the channel for each sample, so the two channels are addressed independently and do not have to alternate. Each accepted write stores a 9-bit entry, the channel bit above the sample, in a 256-deep queue. The queue's write side and read side are controlled separately.

A sample-rate strobe, `smp_tick`, drains the queue. It is a one-cycle clock enable that pulses at twice the per-channel rate (88.2 kHz for 44.1 kHz stereo), because both channels share one stream. On each strobe the entry at the head of the queue is read into a staging register. On the following edge, the other phase of the sample clock, the staged sample is latched into the output register of its channel. When the queue is empty the latch strobe is suppressed and both outputs keep their last values.

A bus read does not return sample data. It returns a status byte holding the queue flags and a sticky overflow bit. The active-high reset acts as the master reset: it clears the queue, its active-low internal form drives the queue, and both outputs return to mid-scale.

Top module: `pcm_dual_streamer`

## Requirements
- R1: While reset is high and after it is released, both channel outputs hold 0x80, the queue is empty and the overflow bit is clear, so a status read returns 0x01.
- R2: A cycle with `bus_cs` and `bus_wr` high queues `bus_wdata` together with `bus_a0`. `bus_a0` = 0 routes the sample to `ch_a_out` and `bus_a0` = 1 routes it to `ch_b_out`. The other channel's output is left unchanged.
- R3: Entries leave the queue in the order they were written, one entry per `smp_tick` pulse.
- R4: If `smp_tick` is high at clock edge n and the queue is not empty, the chosen channel output shows the new sample after edge n+1, and not before.
- R5: An `smp_tick` pulse while the queue is empty changes neither output.
- R6: A cycle with `bus_cs` and `bus_rd` high and `bus_wr` low loads `bus_rdata` at that edge with the status byte: bit 0 empty, bit 1 at least half full (256/2 = 128 or more entries), bit 2 full, bit 3 overflow, bits 7..4 zero. `bus_rdata` holds that value until the next status read.
- R7: The queue holds 256 entries. A write that arrives while the queue is full is dropped and sets the overflow bit. The overflow bit stays set until the next status read, which reports it and then clears it.
- R8: With `bus_cs` low, `bus_wr` and `bus_rd` have no effect on the queue, the outputs or `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| bus_cs | input | 1 | Block select for a bus access |
| bus_wr | input | 1 | Write strobe, pushes one sample |
| bus_rd | input | 1 | Read strobe, captures the status byte |
| bus_a0 | input | 1 | Address bit 0, the channel select for a write |
| bus_wdata | input | 8 | Sample to queue |
| bus_rdata | output | 8 | Registered status byte |
| smp_tick | input | 1 | One-cycle sample-rate strobe |
| ch_a_out | output | 8 | Channel A converter input register |
| ch_b_out | output | 8 | Channel B converter input register |

## Verification
Every result has a fixed latency. A write is in the queue after the edge on which it is strobed. The status byte is valid after the edge that samples the read. A tick moves a sample to the outputs two edges after it is raised. The bench drives its stimuli on falling edges and holds each strobe for exactly one cycle. It then waits the matching number of falling edges and compares the outputs at that falling edge, halfway between rising edges. Queue order is checked by draining a queue filled to capacity and comparing each channel with the last sample written to it.

// File: rtl/pcm_stream_pkg.sv
package pcm_stream_pkg;
  localparam int SMP_W = 8;

  typedef struct packed {
    logic             chan;
    logic [SMP_W-1:0] smp;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  localparam int ST_EMPTY = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVF   = 3;

  localparam logic [SMP_W-1:0] MID_SCALE = SMP_W'(1) << (SMP_W - 1);
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         empty,
  output logic         full,
  output logic         half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pop_ok;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pcm_bus_port.sv
module pcm_bus_port
  import pcm_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_a0,
  input  logic [SMP_W-1:0] bus_wdata,
  input  logic             q_empty,
  input  logic             q_full,
  input  logic             q_half,
  output logic             push,
  output entry_t           push_entry,
  output logic [7:0]       rdata,
  output logic             ovf_flag
);
  logic rd_acc;
  logic [7:0] status;

  assign push            = bus_cs && bus_wr;
  assign rd_acc          = bus_cs && bus_rd && !bus_wr;
  assign push_entry.chan = bus_a0;
  assign push_entry.smp  = bus_wdata;

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = q_empty;
    status[ST_HALF]  = q_half;
    status[ST_FULL]  = q_full;
    status[ST_OVF]   = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      rdata    <= '0;
    end else begin
      if (rd_acc) begin
        rdata    <= status;
        ovf_flag <= 1'b0;
      end else if (push && q_full) begin
        ovf_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_out_stage.sv
module pcm_out_stage
  import pcm_stream_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch,
  input  entry_t           staged,
  output logic [SMP_W-1:0] ch_out [NCH]
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [SW-1:0] sel;
  assign sel = SW'(staged.chan);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        ch_out[i] <= MID_SCALE;
      else if (latch && (sel == SW'(i)))
        ch_out[i] <= staged.smp;
    end
  end
endmodule

// File: rtl/pcm_dual_streamer.sv
module pcm_dual_streamer
  import pcm_stream_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_a0,
  input  logic [SMP_W-1:0] bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             smp_tick,
  output logic [SMP_W-1:0] ch_a_out,
  output logic [SMP_W-1:0] ch_b_out
);
  logic             q_rst_n;
  logic             push_req;
  entry_t           push_entry;
  logic [ENTRY_W-1:0] head_bits;
  entry_t           head;
  logic             fifo_rvalid, fifo_empty, fifo_full, fifo_half;
  logic             ovf_flag;
  logic [SMP_W-1:0] ch_q [2];

  assign q_rst_n = ~rst;
  assign head    = entry_t'(head_bits);

  pcm_bus_port u_bus (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_a0(bus_a0), .bus_wdata(bus_wdata), .q_empty(fifo_empty),
    .q_full(fifo_full), .q_half(fifo_half), .push(push_req),
    .push_entry(push_entry), .rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  pcm_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(q_rst_n), .push(push_req), .wdata(push_entry),
    .pop(smp_tick), .rdata(head_bits), .rvalid(fifo_rvalid),
    .empty(fifo_empty), .full(fifo_full), .half(fifo_half)
  );

  pcm_out_stage #(.NCH(2)) u_out (
    .clk(clk), .rst(rst), .latch(fifo_rvalid), .staged(head), .ch_out(ch_q)
  );

  assign ch_a_out = ch_q[0];
  assign ch_b_out = ch_q[1];
endmodule

// File: rtl/pcm_dual_streamer_chk.sv
module pcm_dual_streamer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_cs,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       smp_tick,
  input logic [7:0] ch_a_out,
  input logic [7:0] ch_b_out,
  input logic       fifo_rvalid,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic       ovf_flag
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fifo_rvalid |=> ($stable(ch_a_out) && $stable(ch_b_out))); // R5

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !(!$stable(ch_a_out) && !$stable(ch_b_out))); // R2

  AST_LATCH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    fifo_rvalid |-> $past(smp_tick)); // R4

  AST_EMPTY_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && fifo_empty) |=> !fifo_rvalid); // R5

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && bus_cs && bus_wr && !smp_tick) |=> fifo_full); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(bus_cs && bus_rd && !bus_wr)) |=> ovf_flag); // R7
endmodule

bind pcm_dual_streamer pcm_dual_streamer_chk u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .smp_tick(smp_tick), .ch_a_out(ch_a_out), .ch_b_out(ch_b_out),
  .fifo_rvalid(fifo_rvalid), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .ovf_flag(ovf_flag)
);

// File: tb/pcm_dual_streamer_bench.sv
module pcm_dual_streamer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       smp_tick = 1'b0;
  logic [7:0] ch_a_out, ch_b_out;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pcm_dual_streamer u_pcm_dual_streamer (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_tick(smp_tick), .ch_a_out(ch_a_out), .ch_b_out(ch_b_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic a0, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    bus_cs = cs; bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] st, input logic cs = 1'b1);
    @(negedge clk);
    bus_cs = cs; bus_rd = 1'b1;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd = 1'b0;
    st = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] st;
    check("R1 ch_a reset", ch_a_out, 8'h80);
    check("R1 ch_b reset", ch_b_out, 8'h80);
    read_status(st);
    check("R1 status after reset", st, 8'h01);
  endtask

  task automatic t_route();
    bus_write(1'b0, 8'h11);
    tick();
    check("R2 ch_a gets a0=0", ch_a_out, 8'h11);
    check("R2 ch_b untouched", ch_b_out, 8'h80);
    bus_write(1'b1, 8'h22);
    tick();
    check("R2 ch_b gets a0=1", ch_b_out, 8'h22);
    check("R2 ch_a untouched", ch_a_out, 8'h11);
  endtask

  task automatic t_latency();
    bus_write(1'b0, 8'h5A);
    @(negedge clk);
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    check("R4 no update one edge after tick", ch_a_out, 8'h11);
    @(negedge clk);
    check("R4 update two edges after tick", ch_a_out, 8'h5A);
  endtask

  task automatic t_order();
    bus_write(1'b0, 8'h33);
    bus_write(1'b1, 8'h44);
    bus_write(1'b0, 8'h55);
    tick();
    check("R3 first entry", ch_a_out, 8'h33);
    tick();
    check("R3 second entry", ch_b_out, 8'h44);
    check("R3 a held", ch_a_out, 8'h33);
    tick();
    check("R3 third entry", ch_a_out, 8'h55);
  endtask

  task automatic t_empty_tick();
    tick();
    tick();
    check("R5 a held on empty", ch_a_out, 8'h55);
    check("R5 b held on empty", ch_b_out, 8'h44);
  endtask

  task automatic t_fill_overflow();
    logic [7:0] st;
    for (int i = 0; i < 128; i++) bus_write(i[0], i[7:0]);
    read_status(st);
    check("R6 half flag", st, 8'h02);
    for (int i = 128; i < 256; i++) bus_write(i[0], i[7:0]);
    read_status(st);
    check("R6 full flag", st, 8'h06);
    bus_write(1'b0, 8'h77);
    read_status(st);
    check("R7 overflow reported", st, 8'h0E);
    read_status(st);
    check("R7 overflow cleared by read", st, 8'h06);
    for (int i = 0; i < 256; i++) tick();
    check("R7 R3 last a sample, drop unseen", ch_a_out, 8'hFE);
    check("R3 last b sample", ch_b_out, 8'hFF);
    read_status(st);
    check("R6 empty after drain", st, 8'h01);
  endtask

  task automatic t_cs_low();
    logic [7:0] st;
    read_status(st);
    bus_write(1'b0, 8'h99, 1'b0);
    tick();
    check("R8 write ignored without cs", ch_a_out, 8'hFE);
    bus_write(1'b0, 8'h99);
    bus_write(1'b0, 8'h98);
    read_status(st, 1'b0);
    check("R8 read ignored without cs", st, 8'h01);
    read_status(st);
    check("R8 queue got only cs writes", st, 8'h00);
  endtask

  task automatic t_master_reset();
    logic [7:0] st;
    do_reset();
    check("R1 a mid after master reset", ch_a_out, 8'h80);
    check("R1 b mid after master reset", ch_b_out, 8'h80);
    read_status(st);
    check("R1 queue cleared", st, 8'h01);
    tick();
    check("R1 nothing left to play", ch_a_out, 8'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ch_a during reset", ch_a_out, 8'h80);
    rst = 1'b0;
    t_reset();
    t_route();
    t_latency();
    t_order();
    t_empty_tick();
    t_fill_overflow();
    t_cs_low();
    t_master_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule